// File: doc/BRIEF.md
# Byte-Serial Transmitter with Completion Flags and Line-Turnaround Output

This block serialises bytes onto an asynchronous serial line. It has a one-byte holding register in front of a shift register. Bit timing comes from a clock-enable input that pulses at eight times the bit rate. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. Software, or a small controller, writes a byte with a strobe. It watches a three-bit status word and can clear the sticky bits with a read strobe.

The status word has three flags. The holding register has room for a byte. A frame has fully finished, which is raised after every frame, even when another byte is already queued. A write was lost because the holding register was full. An interrupt line follows either the holding-register flag or the frame-finished flag, picked by a select input.

A separate `line_busy` output is high from the first start bit until a stop bit ends with nothing left to send. It can drive the driver enable of a half-duplex transceiver directly, so no software delay is needed after the last byte.

Top module: `serial_tx_turnaround`

## Requirements
- R1: After reset `txd` is 1, `line_busy` is 0 and `status` is 3'b001, where bit 0 is holding-register empty, bit 1 is frame finished and bit 2 is write lost.
- R2: A frame is one start bit at 0, then data bits 0 to 7 in that order, then one stop bit at 1. With `tick_en` held at 1, each bit lasts 8 clocks and a frame lasts 80 clocks.
- R3: One bit lasts exactly 8 pulses of `tick_en`. Clocks without `tick_en` do not advance the bit timing.
- R4: A write to an idle transmitter moves it into a setup phase on the next clock. The start bit begins on the 8th tick after that. With `tick_en` at 1, `txd` first reads 0 on the 9th clock after the write clock.
- R5: Status bit 0 falls on the clock after an accepted write. It rises on the clock on which that byte's start bit begins.
- R6: Status bit 1 rises on the clock on which a stop bit ends, after every frame. When a byte is queued, that same clock also raises bit 0 and begins the next start bit.
- R7: Status bit 1 is cleared only by `rd_stb`. If a frame ends on the same clock as the read, the flag stays set.
- R8: A byte that is queued before the current stop bit ends is sent with no idle gap. Frame starts are then exactly 80 clocks apart with `tick_en` at 1.
- R9: A write while the holding register is full is ignored: that byte is never sent. It sets status bit 2, and `rd_stb` clears that bit.
- R10: `irq` equals status bit 0 when `irq_sel` is 0 and status bit 1 when `irq_sel` is 1.
- R11: `line_busy` rises with the first start bit. It stays high across back-to-back frames. It falls on the clock on which a stop bit ends with both the holding register and the shift register empty. `txd` is 1 whenever `line_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable at eight times the bit rate |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Status read; clears bits 1 and 2 |
| irq_sel | input | 1 | Interrupt source: 0 holding empty, 1 frame finished |
| txd | output | 1 | Serial output, idles high |
| line_busy | output | 1 | Driver enable for line turnaround |
| status | output | 3 | {write lost, frame finished, holding empty} |
| irq | output | 1 | Selected interrupt flag |

## Verification
Every result is counted in clocks from the write clock, with `tick_en` held at 1. The start bit appears 9 clocks after the write, and the empty flag rises on that same clock. The frame-finished flag rises, and `line_busy` falls, 80 clocks after the start bit. The bench drives on falling edges and samples the outputs on the falling edge just after the clock edge at which each result is due. In the back-to-back case it polls each sample for the first set frame-finished flag. It then checks that the empty flag and the new start bit appeared in that same sample, and that the empty flag was clear one sample earlier. A small receiver in the bench samples each bit at its fourth clock across all 256 byte values sent back to back. It checks the data and the stop bit, and checks that frame starts are exactly 80 clocks apart. A separate run with a tick every third clock measures a 24-clock start bit.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_START,
    PH_DATA,
    PH_STOP
  } tx_phase_e;
endpackage

// File: rtl/serial_tx_holdreg.sv
module serial_tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              reject
);
  logic              full_d;
  logic [DATA_W-1:0] data_d;

  assign reject = wr_stb && full;

  always_comb begin
    full_d = full;
    data_d = data;
    if (take) full_d = 1'b0;
    if (wr_stb && !full) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end
endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              frame_done,
  output logic              txd,
  output logic              busy
);
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  tx_phase_e         ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              bit_end;

  assign bit_end = tick_en && (cnt_q == CNT_LAST);

  always_comb begin
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    take       = 1'b0;
    frame_done = 1'b0;
    if (tick_en && ph_q != PH_IDLE) cnt_d = bit_end ? '0 : cnt_q + 1'b1;
    case (ph_q)
      PH_IDLE: begin
        if (hold_full) begin
          ph_d  = PH_SETUP;
          cnt_d = '0;
        end
      end
      PH_SETUP: begin
        if (bit_end) begin
          ph_d = PH_START;
          take = 1'b1;
          sh_d = hold_data;
        end
      end
      PH_START: begin
        if (bit_end) begin
          ph_d  = PH_DATA;
          idx_d = '0;
        end
      end
      PH_DATA: begin
        if (bit_end) begin
          sh_d = sh_q >> 1;
          if (idx_q == IDX_LAST) ph_d = PH_STOP;
          else idx_d = idx_q + 1'b1;
        end
      end
      PH_STOP: begin
        if (bit_end) begin
          frame_done = 1'b1;
          if (hold_full) begin
            ph_d = PH_START;
            take = 1'b1;
            sh_d = hold_data;
          end else begin
            ph_d = PH_IDLE;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
    end
  end

  assign busy = (ph_q == PH_START) || (ph_q == PH_DATA) || (ph_q == PH_STOP);
  assign txd  = (ph_q == PH_START) ? 1'b0 : (ph_q == PH_DATA) ? sh_q[0] : 1'b1;
endmodule

// File: rtl/serial_tx_flags.sv
module serial_tx_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic       frame_done,
  input  logic       reject,
  input  logic       hold_full,
  input  logic       irq_sel,
  output logic [2:0] status,
  output logic       irq
);
  logic done_q, done_d;
  logic lost_q, lost_d;

  always_comb begin
    done_d = done_q;
    lost_d = lost_q;
    if (rd_stb) begin
      done_d = 1'b0;
      lost_d = 1'b0;
    end
    if (frame_done) done_d = 1'b1;
    if (reject)     lost_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      done_q <= done_d;
      lost_q <= lost_d;
    end
  end

  assign status = {lost_q, done_q, !hold_full};
  assign irq    = irq_sel ? done_q : !hold_full;
endmodule

// File: rtl/serial_tx_turnaround.sv
module serial_tx_turnaround #(
  parameter int DATA_W = 8,
  parameter int OVS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              irq_sel,
  output logic              txd,
  output logic              line_busy,
  output logic [2:0]        status,
  output logic              irq
);
  logic              hold_full, take, reject, frame_done;
  logic [DATA_W-1:0] hold_data;

  serial_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(take), .full(hold_full), .data(hold_data), .reject(reject)
  );

  serial_tx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hold_full(hold_full),
    .hold_data(hold_data), .take(take), .frame_done(frame_done),
    .txd(txd), .busy(line_busy)
  );

  serial_tx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .frame_done(frame_done),
    .reject(reject), .hold_full(hold_full), .irq_sel(irq_sel),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/serial_tx_turnaround_chk.sv
module serial_tx_turnaround_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       txd,
  input logic       line_busy,
  input logic [2:0] status
);
  // R5
  empty_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(wr_stb));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !rd_stb) |=> status[1]);

  // R9
  lost_on_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !status[0]) |=> status[2]);

  // R6
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(line_busy));

  // R11
  busy_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_busy) |-> !txd);

  // R11
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_busy |-> txd);
endmodule

bind serial_tx_turnaround serial_tx_turnaround_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .txd(txd), .line_busy(line_busy), .status(status)
);

// File: tb/serial_tx_turnaround_test.sv
module serial_tx_turnaround_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_stb = 1'b0;
  logic       irq_sel = 1'b0;
  logic       txd, line_busy, irq;
  logic [2:0] status;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_div = 1;
  int tdc = 0;

  // bench receiver
  logic       rx_on = 1'b1;
  logic       rx_busy = 1'b0;
  int         rx_cnt = 0;
  int         rx_n = 0;
  logic [7:0] rx_byte = '0;
  logic [7:0] exp_q [0:511];
  int         exp_n = 0;
  int         st_cyc [0:511];

  serial_tx_turnaround uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .irq_sel(irq_sel), .txd(txd),
    .line_busy(line_busy), .status(status), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (tick_div <= 1) tick_en = 1'b1;
    else begin
      tick_en = (tdc == 0);
      tdc = (tdc + 1 >= tick_div) ? 0 : tdc + 1;
    end
    if (rx_on && rst_n) begin
      if (!rx_busy) begin
        if (!txd) begin
          rx_busy = 1'b1;
          rx_cnt = 0;
          st_cyc[rx_n] = cyc;
        end
      end else begin
        rx_cnt++;
        if (rx_cnt >= 11 && rx_cnt <= 67 && (rx_cnt % 8) == 3)
          rx_byte[(rx_cnt - 11) / 8] = txd;
        if (rx_cnt == 75) begin
          chk(txd == 1'b1, "R2 stop bit", int'(txd), 1);
          chk(rx_byte == exp_q[rx_n], "R2 received byte", int'(rx_byte), int'(exp_q[rx_n]));
          rx_n++;
          rx_busy = 1'b0;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] b, input logic expect_sent);
    @(negedge clk);
    wr_stb = 1'b1;
    wr_data = b;
    if (expect_sent) begin
      exp_q[exp_n] = b;
      exp_n++;
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wait_idle();
    while (line_busy || !status[0]) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int low_len;
    int rx_before;
    logic prev_empty;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(line_busy == 1'b0, "R1 line_busy", int'(line_busy), 0);
    chk(status == 3'b001, "R1 status", int'(status), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 3'b001, "R1 status after release", int'(status), 1);
    chk(irq == 1'b1, "R10 irq on empty", int'(irq), 1);

    // R4 R5 R11 single frame from idle
    wr(8'hA5, 1'b1);
    chk(status[0] == 1'b0, "R5 empty falls after write", int'(status[0]), 0);
    repeat (8) @(negedge clk);
    chk(txd == 1'b1, "R4 no start before 9th clock", int'(txd), 1);
    chk(status[0] == 1'b0, "R5 still full in setup", int'(status[0]), 0);
    chk(line_busy == 1'b0, "R11 not busy in setup", int'(line_busy), 0);
    @(negedge clk);
    chk(txd == 1'b0, "R4 start bit on 9th clock", int'(txd), 0);
    chk(status[0] == 1'b1, "R5 empty at start bit", int'(status[0]), 1);
    chk(line_busy == 1'b1, "R11 busy at start bit", int'(line_busy), 1);
    irq_sel = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq follows done flag", int'(irq), 0);
    repeat (78) @(negedge clk);
    chk(status[1] == 1'b0, "R6 done not before stop end", int'(status[1]), 0);
    chk(line_busy == 1'b1, "R11 busy through stop bit", int'(line_busy), 1);
    chk(txd == 1'b1, "R2 stop bit level", int'(txd), 1);
    @(negedge clk);
    chk(status[1] == 1'b1, "R6 done at stop end", int'(status[1]), 1);
    chk(line_busy == 1'b0, "R11 busy falls at stop end", int'(line_busy), 0);
    chk(irq == 1'b1, "R10 irq done selected", int'(irq), 1);

    // R7 sticky until read
    repeat (20) @(negedge clk);
    chk(status[1] == 1'b1, "R7 done stays without read", int'(status[1]), 1);
    rd();
    chk(status[1] == 1'b0, "R7 read clears done", int'(status[1]), 0);
    chk(status[0] == 1'b1, "R7 read keeps empty", int'(status[0]), 1);
    irq_sel = 1'b0;

    // R6 R8 R11 back to back
    wr(8'h3C, 1'b1);
    while (!status[0]) @(negedge clk);
    wr(8'hC3, 1'b1);
    prev_empty = status[0];
    while (!status[1]) begin
      prev_empty = status[0];
      @(negedge clk);
    end
    chk(prev_empty == 1'b0, "R6 empty low before frame end", int'(prev_empty), 0);
    chk(status[0] == 1'b1, "R6 empty with done", int'(status[0]), 1);
    chk(txd == 1'b0, "R8 next start with done", int'(txd), 0);
    chk(line_busy == 1'b1, "R11 busy kept between frames", int'(line_busy), 1);
    wait_idle();
    rd();

    // R9 write while full
    rx_before = rx_n;
    wr(8'h11, 1'b1);
    wr(8'h22, 1'b0);
    chk(status[2] == 1'b1, "R9 lost flag set", int'(status[2]), 1);
    wait_idle();
    chk(rx_n == rx_before + 1, "R9 only one frame sent", rx_n - rx_before, 1);
    chk(status[2] == 1'b1, "R9 lost flag sticky", int'(status[2]), 1);
    rd();
    chk(status[2] == 1'b0, "R9 read clears lost", int'(status[2]), 0);

    // R2 R8 sweep of all byte values back to back
    rx_before = rx_n;
    for (int b = 0; b < 256; b++) begin
      while (!status[0]) @(negedge clk);
      wr(8'(b), 1'b1);
    end
    wait_idle();
    chk(rx_n == rx_before + 256, "R2 all frames received", rx_n - rx_before, 256);
    for (int k = 1; k < 256; k++)
      chk(st_cyc[rx_before + k] - st_cyc[rx_before + k - 1] == 80, "R8 frame spacing",
          st_cyc[rx_before + k] - st_cyc[rx_before + k - 1], 80);
    rd();

    // R3 gated ticks every third clock
    rx_on = 1'b0;
    tick_div = 3;
    wr(8'h01, 1'b0);
    while (txd) @(negedge clk);
    low_len = 0;
    while (!txd) begin
      low_len++;
      @(negedge clk);
    end
    chk(low_len == 24, "R3 start bit is 8 ticks", low_len, 24);
    while (line_busy) @(negedge clk);
    chk(status[1] == 1'b1, "R3 done after gated frame", int'(status[1]), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule